// File: doc/BRIEF.md
# Sensor-Triggered Two-Road Junction Light Controller

This block drives the green indications at a junction where a major road meets a minor road. The major road keeps its green until a sensor on the minor road reports a waiting car. The minor road then receives a green of fixed length, after which the green returns to the major road.

The design is split into two linked state machines. The phase machine owns the lights and has two states, `PH_MAJOR_GO` (major green, minor red) and `PH_MINOR_GO` (major red, minor green). Its transitions are *car seen* (`PH_MAJOR_GO` to `PH_MINOR_GO` when `car` is high) and *dwell over* (`PH_MINOR_GO` to `PH_MAJOR_GO` when the timer reports timeout). A separate dwell timer has the states `TM_IDLE` (count cleared) and `TM_COUNT` (count advancing). Its transitions are *armed* (`TM_IDLE` to `TM_COUNT` on `start_timer`) and *expired* (`TM_COUNT` to `TM_IDLE` when the count equals `LIMIT`). The two machines are joined only by the start and timeout handshake, so the length of the green phase is set by one parameter and not by a long chain of states.

Top module: `junction_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `major_go`=1, `minor_go`=0, `phase_dbg`=0, `timed_dbg`=0 and `start_timer`=0.
- R2: `start_timer` is a Mealy output. In phase 0 (major green) it follows `car` in the same cycle, and in phase 1 (minor green) it is 0.
- R3: When `car` is high in phase 0 at a rising clock edge, `phase_dbg` is 1 in the next cycle.
- R4: `minor_go` stays high for exactly `LIMIT`+1 consecutive cycles. Counted from the cycle in which `car` is sampled through the last minor-green cycle, the span is `LIMIT`+2 cycles. Phase 0 follows.
- R5: `car` has no effect in phase 1. Holding or toggling it there does not change the length of the minor green.
- R6: `major_go` and `minor_go` are never both high and never both low. `major_go` is high exactly when `phase_dbg` is 0.
- R7: `timed_dbg` goes high for exactly one cycle per minor green, and that cycle is the last minor-green cycle.
- R8: With `car` low, phase 0 holds indefinitely.
- R9: If `car` is still high when phase 0 returns, phase 0 lasts exactly one cycle, with `start_timer` high, before the next minor green.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| car | input | 1 | Minor-road sensor, synchronous to clk |
| major_go | output | 1 | Major road green |
| minor_go | output | 1 | Minor road green |
| start_timer | output | 1 | Timer start request (debug) |
| phase_dbg | output | 1 | Present phase: 0 major green, 1 minor green |
| timed_dbg | output | 1 | Timer timeout flag (debug) |

## Verification
The hardest situation to reach is the edge of the handshake. Here `car` is high in the same cycle that `timed_dbg` fires, and it stays high into the returning major phase. The timer has to re-arm from a count it has just left, and the major green must last exactly one cycle. The stimulus reaches this by holding `car` high across several full minor phases and by raising it exactly in the timeout cycle. A scoreboard model checks every cycle's outputs, and a separate run-length monitor measures each minor green.

// File: rtl/jc_pkg.sv
package jc_pkg;
    typedef enum logic {
        PH_MAJOR_GO = 1'b0,
        PH_MINOR_GO = 1'b1
    } phase_t;

    typedef enum logic {
        TM_IDLE  = 1'b0,
        TM_COUNT = 1'b1
    } tmr_t;
endpackage

// File: rtl/jc_timer.sv
module jc_timer
    import jc_pkg::*;
#(
    parameter int LIMIT = 255,
    parameter int CW    = $clog2(LIMIT + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic timeout
);
    tmr_t          st, st_nx;
    logic [CW-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TM_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        unique case (st)
            TM_IDLE:  st_nx = start   ? TM_COUNT : TM_IDLE;
            TM_COUNT: st_nx = timeout ? TM_IDLE  : TM_COUNT;
            default:  st_nx = TM_IDLE;
        endcase
    end

    // dwell counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (st)
                TM_IDLE:  cnt <= '0;
                TM_COUNT: cnt <= cnt + 1'b1;
                default:  cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            TM_COUNT: timeout = (cnt == CW'(LIMIT));
            default:  timeout = 1'b0;
        endcase
    end

    // R4: an armed timer starts counting from zero
    assert_arm_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TM_IDLE && start) |=> (st == TM_COUNT && cnt == '0));

    // R4: the count never runs past the limit
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TM_COUNT) |-> (cnt <= CW'(LIMIT)));

    // R7: the timeout flag is a single-cycle pulse
    assert_timeout_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);
endmodule

// File: rtl/jc_phase_fsm.sv
module jc_phase_fsm
    import jc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   car,
    input  logic   timed,
    output phase_t phase,
    output logic   start_timer,
    output logic   major_go,
    output logic   minor_go
);
    phase_t ph_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_MAJOR_GO;
        else        phase <= ph_nx;
    end

    // next state: car seen / dwell over
    always_comb begin
        unique case (phase)
            PH_MAJOR_GO: ph_nx = car   ? PH_MINOR_GO : PH_MAJOR_GO;
            PH_MINOR_GO: ph_nx = timed ? PH_MAJOR_GO : PH_MINOR_GO;
            default:     ph_nx = PH_MAJOR_GO;
        endcase
    end

    // outputs: lights are Moore, the start request is Mealy
    always_comb begin
        unique case (phase)
            PH_MAJOR_GO: begin
                major_go    = 1'b1;
                minor_go    = 1'b0;
                start_timer = car;
            end
            PH_MINOR_GO: begin
                major_go    = 1'b0;
                minor_go    = 1'b1;
                start_timer = 1'b0;
            end
            default: begin
                major_go    = 1'b1;
                minor_go    = 1'b0;
                start_timer = 1'b0;
            end
        endcase
    end

    // R3: a sensed car hands the green to the minor road next cycle
    assert_car_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MAJOR_GO && car) |=> (phase == PH_MINOR_GO));

    // R5: without timeout the minor phase holds whatever car does
    assert_minor_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MINOR_GO && !timed) |=> (phase == PH_MINOR_GO));

    // R8: no car keeps the major road green
    assert_major_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MAJOR_GO && !car) |=> (phase == PH_MAJOR_GO));

    // R6: exactly one road is green
    assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({major_go, minor_go}));
endmodule

// File: rtl/junction_ctrl.sv
module junction_ctrl
    import jc_pkg::*;
#(
    parameter int LIMIT = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic car,
    output logic major_go,
    output logic minor_go,
    output logic start_timer,
    output logic phase_dbg,
    output logic timed_dbg
);
    localparam int CW = $clog2(LIMIT + 2);

    phase_t phase;
    logic   start_w;
    logic   timed_w;

    jc_phase_fsm u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .car         (car),
        .timed       (timed_w),
        .phase       (phase),
        .start_timer (start_w),
        .major_go    (major_go),
        .minor_go    (minor_go)
    );

    jc_timer #(
        .LIMIT (LIMIT),
        .CW    (CW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_w),
        .timeout (timed_w)
    );

    assign start_timer = start_w;
    assign phase_dbg   = phase;
    assign timed_dbg   = timed_w;

    // R7: timeout only arrives during the minor green
    assert_timed_in_minor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timed_w |-> (phase == PH_MINOR_GO));

    // R4: timeout ends the minor green at the next edge
    assert_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timed_w |=> (phase == PH_MAJOR_GO));
endmodule

// File: tb/sim_junction_ctrl.sv
module sim_junction_ctrl;
    localparam int LIMIT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic car = 1'b0;
    logic major_go, minor_go, start_timer, phase_dbg, timed_dbg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    junction_ctrl #(.LIMIT(LIMIT)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .car         (car),
        .major_go    (major_go),
        .minor_go    (minor_go),
        .start_timer (start_timer),
        .phase_dbg   (phase_dbg),
        .timed_dbg   (timed_dbg)
    );

    // scoreboard: expected {major, minor, start, timed, phase} and tag
    logic [4:0] exp_q[$];
    string      tag_q[$];

    // bench model built from the requirements
    bit m_minor = 1'b0;
    int m_left  = 0;
    bit m_was_minor = 1'b0;

    task automatic step(input bit c);
        logic [4:0] e;
        string t;
        @(negedge clk);
        car = c;
        e[4] = !m_minor;
        e[3] = m_minor;
        e[2] = !m_minor && c;
        e[1] = m_minor && (m_left == 1);
        e[0] = m_minor;
        if (!m_minor)      t = c ? (m_was_minor ? "R9" : "R3/R2") : "R8";
        else if (e[1])     t = "R7";
        else if (c)        t = "R5";
        else               t = "R4";
        exp_q.push_back(e);
        tag_q.push_back(t);
        m_was_minor = m_minor;
        if (!m_minor) begin
            if (c) begin
                m_minor = 1'b1;
                m_left  = LIMIT + 1;
            end
        end else begin
            m_left--;
            if (m_left == 0) m_minor = 1'b0;
        end
    endtask

    // monitor: compare each cycle against the scoreboard
    int run_len = 0;
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [4:0] e, g;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            g = {major_go, minor_go, start_timer, timed_dbg, phase_dbg};
            checks++;
            if (g !== e) begin
                errors++;
                $display("FAIL %s cycle outputs got %b exp %b", t, g, e);
            end
            checks++;
            if (major_go === minor_go || major_go !== !phase_dbg) begin
                errors++;
                $display("FAIL R6 light pair got %b%b phase %b exp one-hot",
                         major_go, minor_go, phase_dbg);
            end
        end
        if (rst_n) begin
            if (minor_go === 1'b1) begin
                run_len++;
            end else if (run_len != 0) begin
                checks++;
                if (run_len != LIMIT + 1) begin
                    errors++;
                    $display("FAIL R4 minor green length got %0d exp %0d",
                             run_len, LIMIT + 1);
                end
                run_len = 0;
            end
        end
    end

    task automatic check_reset();
        logic [4:0] g;
        g = {major_go, minor_go, start_timer, phase_dbg, timed_dbg};
        checks++;
        if (g !== 5'b10000) begin
            errors++;
            $display("FAIL R1 reset outputs got %b exp %b", g, 5'b10000);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check_reset();
        rst_n = 1'b1;
        #1;
        check_reset();
        // R8: long quiet major phase
        repeat (20) step(1'b0);
        // R3/R4: single-cycle car pulse
        step(1'b1);
        repeat (12) step(1'b0);
        // R5: car toggling through the minor phase
        step(1'b1);
        for (int i = 0; i < LIMIT + 1; i++) step(i[0]);
        repeat (5) step(1'b0);
        // R9: car held across several phases
        repeat (4 * (LIMIT + 2) + 3) step(1'b1);
        repeat (10) step(1'b0);
        // R7/R5: car rises exactly in the timeout cycle
        step(1'b1);
        repeat (LIMIT) step(1'b0);
        step(1'b1);
        step(1'b1);
        repeat (12) step(1'b0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule